// File: doc/BRIEF.md
# Static Branch Prediction Fetch Controller

This block picks the next fetch address for a five-stage in-order pipeline with 32-bit, word-aligned instructions. A pre-decode flag marks each fetched instruction as a branch, so the block can act while the instruction is still in fetch. Direction comes from the sign of the branch offset. A negative offset is a loop-closing jump and is guessed taken. A zero or positive offset is guessed not taken. The guess and its target travel with the branch through the decode and execute pipeline registers, which live inside this block.

The real outcome is known only in execute. When it disagrees with the guess, the block squashes the two younger instructions in decode and execute. In the same cycle it steers fetch to the correct path, and this recovery wins over any stall or new guess. A build parameter selects a second variant that makes no guess at all. After fetching a branch it inserts two bubbles and then resumes fetch from the resolved path. A small sequencer with three states controls this: `S_RUN` (normal fetch), `S_SLOT1` (branch in decode, fetch suppressed) and `S_SLOT2` (branch in execute, redirect from its outcome). Its transitions are RUN→SLOT1 when a branch is fetched without stall, SLOT1→SLOT2 and SLOT2→RUN on each unstalled cycle, and a self-loop whenever the stall input is high. In the predicting variant the sequencer never leaves `S_RUN`.

Top module: `bp_fetch_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, fetch_pc_o is 0 and id_valid_o and ex_valid_o are 0.
- R2: With stall_i low, no misprediction and if_branch_i low, the next fetch_pc_o is the current fetch_pc_o plus 4.
- R3: Predicting variant: with stall_i low, no misprediction, if_branch_i high and if_offset_i negative (bit 31 set), the next fetch_pc_o is fetch_pc_o plus if_offset_i.
- R4: Predicting variant: with stall_i low, no misprediction, if_branch_i high and if_offset_i zero or positive, the next fetch_pc_o is fetch_pc_o plus 4.
- R5: mispredict_o and flush_o are high in exactly those cycles where execute holds a valid branch and either ex_taken_i differs from the guess, or ex_taken_i is high and ex_target_i differs from the guessed target.
- R6: After a misprediction, fetch_pc_o is ex_target_i if ex_taken_i was high, else ex_pc_o plus 4. This overrides the guess for the branch then in fetch. redirect_o is high in that cycle.
- R7: On the cycle after a misprediction, id_valid_o and ex_valid_o are both 0.
- R8: With stall_i high and redirect_o low, fetch_pc_o, id_valid_o and ex_valid_o keep their values on the next cycle.
- R9: A misprediction performs its recovery (R6, R7) even when stall_i is high in the same cycle.
- R10: With stall_i low and no misprediction, the decode entry (id_valid_o, id_pc_o) moves to execute (ex_valid_o, ex_pc_o, ex_branch_o). Decode then takes the fetched instruction with its PC and is valid unless a bubble is inserted.
- R11: Stall-only variant: mispredict_o is never high. A branch fetched without stall is followed by two invalid decode entries. The fetch after those is at ex_target_i if taken, else branch PC plus 4, and redirect_o is high in the resolving cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freezes PC and pipeline registers when high |
| if_branch_i | input | 1 | Pre-decode flag: instruction at fetch_pc_o is a branch |
| if_offset_i | input | 32 | Signed byte offset of that branch |
| ex_taken_i | input | 1 | Resolved direction of the branch in execute |
| ex_target_i | input | 32 | Resolved taken target of the branch in execute |
| fetch_pc_o | output | 32 | Current fetch address |
| id_valid_o | output | 1 | Decode entry holds a live instruction |
| id_pc_o | output | 32 | PC of the decode entry |
| ex_valid_o | output | 1 | Execute entry holds a live instruction |
| ex_pc_o | output | 32 | PC of the execute entry |
| ex_branch_o | output | 1 | Execute entry is a branch |
| mispredict_o | output | 1 | Execute branch outcome disagrees with the guess |
| flush_o | output | 1 | Squash decode and execute entries at the coming edge |
| redirect_o | output | 1 | Fetch is steered from the execute outcome at the coming edge |

## Verification
Several properties are checked on every clock edge: the reset values, the link between a misprediction and a valid execute-stage branch, the recovery address, the squash of both younger entries, the stall freeze, and the sign-based next-PC choice. In the stall-only build, the check is that no misprediction is ever raised. Some behaviour only the bench scenarios can show. These are the full hand-off of PCs and branch flags from decode to execute, and the interaction of recovery with a stall in the same cycle. They also include the two-bubble spacing of the stall-only variant and the target-mismatch case under long random mixes of branches, stalls and outcomes.

// File: rtl/bp_fetch_pkg.sv
package bp_fetch_pkg;
    localparam int PC_W       = 32;
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_SLOT1 = 2'd1,
        S_SLOT2 = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            valid;
        logic            branch;
        logic            pred_taken;
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] pred_target;
    } stage_t;
endpackage

// File: rtl/bp_dir_pred.sv
module bp_dir_pred
    import bp_fetch_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            is_branch_i,
    input  logic [PC_W-1:0] offset_i,
    output logic            pred_taken_o,
    output logic [PC_W-1:0] pred_target_o,
    output logic [PC_W-1:0] seq_pc_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    assign pred_target_o = pc_i + offset_i;
    assign seq_pc_o      = pc_i + STEP;

    generate
        if (ENABLE) begin : g_sign
            // backward (negative) offset guessed taken
            assign pred_taken_o = is_branch_i & offset_i[PC_W-1];
        end else begin : g_none
            assign pred_taken_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/bp_stage_reg.sv
module bp_stage_reg
    import bp_fetch_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold_i,
    input  logic   kill_i,
    input  stage_t d_i,
    output stage_t q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (kill_i) begin
            q_o.valid <= 1'b0;
        end else if (!hold_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/bp_seq_fsm.sv
module bp_seq_fsm
    import bp_fetch_pkg::*;
#(
    parameter bit WAIT_ON_BRANCH = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_i,
    input  logic fetch_branch_i,
    output logic bubble_o,
    output logic pc_hold_o,
    output logic resolve_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        bubble_o  = 1'b0;
        pc_hold_o = 1'b0;
        resolve_o = 1'b0;
        unique case (state_q)
            S_RUN: begin
                pc_hold_o = WAIT_ON_BRANCH & fetch_branch_i;
                if (WAIT_ON_BRANCH && fetch_branch_i && !stall_i)
                    state_d = S_SLOT1;
            end
            S_SLOT1: begin
                bubble_o  = 1'b1;
                pc_hold_o = 1'b1;
                if (!stall_i) state_d = S_SLOT2;
            end
            S_SLOT2: begin
                bubble_o  = 1'b1;
                resolve_o = !stall_i;
                if (!stall_i) state_d = S_RUN;
            end
            default: state_d = S_RUN;
        endcase
    end
endmodule

// File: rtl/bp_fetch_ctrl.sv
module bp_fetch_ctrl
    import bp_fetch_pkg::*;
#(
    parameter bit PREDICT_BTFN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  logic            if_branch_i,
    input  logic [PC_W-1:0] if_offset_i,
    input  logic            ex_taken_i,
    input  logic [PC_W-1:0] ex_target_i,
    output logic [PC_W-1:0] fetch_pc_o,
    output logic            id_valid_o,
    output logic [PC_W-1:0] id_pc_o,
    output logic            ex_valid_o,
    output logic [PC_W-1:0] ex_pc_o,
    output logic            ex_branch_o,
    output logic            mispredict_o,
    output logic            flush_o,
    output logic            redirect_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic [PC_W-1:0] pc_q, pc_d, pred_target, seq_pc, recover_pc;
    logic            pred_taken, mispredict, bubble, pc_hold, resolve, hold;
    stage_t          ifid_d, ifid_q, idex_q;

    bp_dir_pred #(.ENABLE(PREDICT_BTFN)) u_pred (
        .pc_i         (pc_q),
        .is_branch_i  (if_branch_i),
        .offset_i     (if_offset_i),
        .pred_taken_o (pred_taken),
        .pred_target_o(pred_target),
        .seq_pc_o     (seq_pc)
    );

    bp_seq_fsm #(.WAIT_ON_BRANCH(!PREDICT_BTFN)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall_i),
        .fetch_branch_i(if_branch_i),
        .bubble_o      (bubble),
        .pc_hold_o     (pc_hold),
        .resolve_o     (resolve)
    );

    generate
        if (PREDICT_BTFN) begin : g_cmp
            assign mispredict = idex_q.valid & idex_q.branch &
                ((ex_taken_i != idex_q.pred_taken) |
                 (ex_taken_i & (ex_target_i != idex_q.pred_target)));
        end else begin : g_nocmp
            assign mispredict = 1'b0;
        end
    endgenerate

    assign recover_pc = ex_taken_i ? ex_target_i : (idex_q.pc + STEP);
    assign hold       = stall_i & ~mispredict;

    always_comb begin
        ifid_d.valid       = ~bubble;
        ifid_d.branch      = if_branch_i;
        ifid_d.pred_taken  = pred_taken;
        ifid_d.pc          = pc_q;
        ifid_d.pred_target = pred_target;
    end

    bp_stage_reg u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .hold_i(hold),
        .kill_i(mispredict),
        .d_i   (ifid_d),
        .q_o   (ifid_q)
    );

    bp_stage_reg u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .hold_i(hold),
        .kill_i(mispredict),
        .d_i   (ifid_q),
        .q_o   (idex_q)
    );

    always_comb begin
        if (mispredict)      pc_d = recover_pc;
        else if (stall_i)    pc_d = pc_q;
        else if (resolve)    pc_d = recover_pc;
        else if (pc_hold)    pc_d = pc_q;
        else if (pred_taken) pc_d = pred_target;
        else                 pc_d = seq_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign fetch_pc_o   = pc_q;
    assign id_valid_o   = ifid_q.valid;
    assign id_pc_o      = ifid_q.pc;
    assign ex_valid_o   = idex_q.valid;
    assign ex_pc_o      = idex_q.pc;
    assign ex_branch_o  = idex_q.branch;
    assign mispredict_o = mispredict;
    assign flush_o      = mispredict;
    assign redirect_o   = mispredict | resolve;
endmodule

// File: rtl/bp_fetch_ctrl_chk.sv
module bp_fetch_ctrl_chk #(
    parameter bit PREDICT_BTFN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        stall_i,
    input logic        if_branch_i,
    input logic [31:0] if_offset_i,
    input logic        ex_taken_i,
    input logic [31:0] ex_target_i,
    input logic [31:0] fetch_pc_o,
    input logic        id_valid_o,
    input logic        ex_valid_o,
    input logic [31:0] ex_pc_o,
    input logic        ex_branch_o,
    input logic        mispredict_o,
    input logic        redirect_o
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (fetch_pc_o == 32'd0 && !id_valid_o && !ex_valid_o));

    a_r5_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_o |-> (ex_valid_o && ex_branch_o));

    a_r6_recovery_pc: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_o |=> fetch_pc_o == $past(ex_taken_i ? ex_target_i : ex_pc_o + 32'd4));

    a_r7_squash_both: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict_o |=> (!id_valid_o && !ex_valid_o));

    a_r8_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !redirect_o) |=>
            ($stable(fetch_pc_o) && $stable(id_valid_o) && $stable(ex_valid_o)));

    generate
        if (PREDICT_BTFN) begin : g_btfn
            a_r2_sequential: assert property (@(posedge clk) disable iff (!rst_n)
                (!stall_i && !mispredict_o && !if_branch_i) |=>
                    fetch_pc_o == $past(fetch_pc_o) + 32'd4);

            a_r3_backward_taken: assert property (@(posedge clk) disable iff (!rst_n)
                (!stall_i && !mispredict_o && if_branch_i && if_offset_i[31]) |=>
                    fetch_pc_o == $past(fetch_pc_o + if_offset_i));

            a_r4_forward_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
                (!stall_i && !mispredict_o && if_branch_i && !if_offset_i[31]) |=>
                    fetch_pc_o == $past(fetch_pc_o) + 32'd4);
        end else begin : g_wait
            a_r11_no_mispredict: assert property (@(posedge clk) disable iff (!rst_n)
                !mispredict_o);
        end
    endgenerate
endmodule

bind bp_fetch_ctrl bp_fetch_ctrl_chk #(.PREDICT_BTFN(PREDICT_BTFN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .if_branch_i (if_branch_i),
    .if_offset_i (if_offset_i),
    .ex_taken_i  (ex_taken_i),
    .ex_target_i (ex_target_i),
    .fetch_pc_o  (fetch_pc_o),
    .id_valid_o  (id_valid_o),
    .ex_valid_o  (ex_valid_o),
    .ex_pc_o     (ex_pc_o),
    .ex_branch_o (ex_branch_o),
    .mispredict_o(mispredict_o),
    .redirect_o  (redirect_o)
);

// File: tb/bp_fetch_ctrl_tb.sv
`timescale 1ns/1ps
module bp_fetch_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall_i = 1'b0;
    always #4 clk = ~clk;

    // index 0: predicting build, index 1: stall-only build
    logic        if_br  [2];
    logic [31:0] if_off [2];
    logic        ex_tk  [2];
    logic [31:0] ex_tg  [2];
    logic [31:0] fpc    [2];
    logic        idv    [2];
    logic [31:0] idpc   [2];
    logic        exv    [2];
    logic [31:0] expc   [2];
    logic        exbr   [2];
    logic        mis    [2];
    logic        fl     [2];
    logic        rd     [2];

    bp_fetch_ctrl #(.PREDICT_BTFN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .if_branch_i(if_br[0]), .if_offset_i(if_off[0]),
        .ex_taken_i(ex_tk[0]), .ex_target_i(ex_tg[0]),
        .fetch_pc_o(fpc[0]), .id_valid_o(idv[0]), .id_pc_o(idpc[0]),
        .ex_valid_o(exv[0]), .ex_pc_o(expc[0]), .ex_branch_o(exbr[0]),
        .mispredict_o(mis[0]), .flush_o(fl[0]), .redirect_o(rd[0]));

    bp_fetch_ctrl #(.PREDICT_BTFN(1'b0)) u_stl (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .if_branch_i(if_br[1]), .if_offset_i(if_off[1]),
        .ex_taken_i(ex_tk[1]), .ex_target_i(ex_tg[1]),
        .fetch_pc_o(fpc[1]), .id_valid_o(idv[1]), .id_pc_o(idpc[1]),
        .ex_valid_o(exv[1]), .ex_pc_o(expc[1]), .ex_branch_o(exbr[1]),
        .mispredict_o(mis[1]), .flush_o(fl[1]), .redirect_o(rd[1]));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    // reference model state
    logic [31:0] m_pc[2], m_idpc[2], m_idtg[2], m_expc[2], m_extg[2];
    bit          m_idv[2], m_idbr[2], m_idpt[2], m_exv[2], m_exbr[2], m_expt[2];
    int          m_st[2];
    string       tag_pc[2], tag_v[2];

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed;
    endfunction

    function automatic bit prog_br(logic [31:0] pc);
        return (pc[4:2] == 3'd3) || (pc[4:2] == 3'd6);
    endfunction

    function automatic logic [31:0] prog_off(logic [31:0] pc);
        case (pc[7:6])
            2'd0:    return 32'hFFFF_FFE8;
            2'd1:    return 32'd16;
            2'd2:    return 32'd0;
            default: return 32'hFFFF_FFF8;
        endcase
    endfunction

    task automatic chk(string req, string what, int m, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s (build %0d): actual %h expected %h", req, what, m, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_pc[m] = '0; m_idv[m] = 0; m_exv[m] = 0; m_st[m] = 0;
            m_idpc[m] = '0; m_idtg[m] = '0; m_idbr[m] = 0; m_idpt[m] = 0;
            m_expc[m] = '0; m_extg[m] = '0; m_exbr[m] = 0; m_expt[m] = 0;
            tag_pc[m] = "R1"; tag_v[m] = "R1";
        end
    endtask

    task automatic check_regs(int m);
        chk(tag_pc[m], "fetch_pc", m, fpc[m], m_pc[m]);
        chk(tag_v[m], "id_valid", m, 32'(idv[m]), 32'(m_idv[m]));
        chk(tag_v[m], "ex_valid", m, 32'(exv[m]), 32'(m_exv[m]));
        if (m_idv[m]) chk("R10", "id_pc", m, idpc[m], m_idpc[m]);
        if (m_exv[m]) begin
            chk("R10", "ex_pc", m, expc[m], m_expc[m]);
            chk("R10", "ex_branch", m, 32'(exbr[m]), 32'(m_exbr[m]));
        end
    endtask

    task automatic drive(logic [31:0] r);
        stall_i = (r[1:0] == 2'd0);
        for (int m = 0; m < 2; m++) begin
            if_br[m]  = prog_br(m_pc[m]);
            if_off[m] = prog_off(m_pc[m]);
            ex_tk[m]  = r[2+m] ^ r[9];
            if (m_exv[m] && m_exbr[m])
                ex_tg[m] = m_expc[m] + prog_off(m_expc[m]) + ((r[5:4] == 2'd0) ? 32'd8 : 32'd0);
            else
                ex_tg[m] = {r[31:10], 2'b00, r[17:10]};
        end
    endtask

    task automatic step(int m);
        bit s, b, t, e_mis, e_res, pred, bub;
        logic [31:0] g, o, rec, tgt;
        s = stall_i; b = if_br[m]; o = if_off[m]; t = ex_tk[m]; g = ex_tg[m];
        e_mis = (m == 0) && m_exv[m] && m_exbr[m] &&
                ((t != m_expt[m]) || (t && (g != m_extg[m])));
        e_res = (m == 1) && (m_st[m] == 2) && !s;
        rec   = t ? g : m_expc[m] + 32'd4;
        pred  = (m == 0) && b && o[31];
        tgt   = m_pc[m] + o;
        chk((m == 1) ? "R11" : "R5", "mispredict", m, 32'(mis[m]), 32'(e_mis));
        chk("R5", "flush", m, 32'(fl[m]), 32'(e_mis));
        chk((m == 1) ? "R11" : "R6", "redirect", m, 32'(rd[m]), 32'(e_mis || e_res));
        if (e_mis)       tag_pc[m] = s ? "R9" : "R6";
        else if (s)      tag_pc[m] = "R8";
        else if (m == 1) tag_pc[m] = "R11";
        else if (pred)   tag_pc[m] = "R3";
        else if (b)      tag_pc[m] = "R4";
        else             tag_pc[m] = "R2";
        if (e_mis)                      tag_v[m] = s ? "R9" : "R7";
        else if (s)                     tag_v[m] = "R8";
        else if (m == 1 && m_st[m] != 0) tag_v[m] = "R11";
        else                            tag_v[m] = "R10";
        if (e_mis) begin
            m_pc[m] = rec; m_idv[m] = 0; m_exv[m] = 0;
        end else if (!s) begin
            bub = (m_st[m] != 0);
            m_exv[m] = m_idv[m]; m_expc[m] = m_idpc[m]; m_exbr[m] = m_idbr[m];
            m_expt[m] = m_idpt[m]; m_extg[m] = m_idtg[m];
            m_idv[m] = !bub; m_idpc[m] = m_pc[m]; m_idbr[m] = b;
            m_idpt[m] = pred; m_idtg[m] = tgt;
            if (e_res)                                m_pc[m] = rec;
            else if (m_st[m] == 1)                    m_pc[m] = m_pc[m];
            else if (m == 1 && m_st[m] == 0 && b)     m_pc[m] = m_pc[m];
            else if (pred)                            m_pc[m] = tgt;
            else                                      m_pc[m] = m_pc[m] + 32'd4;
            if (m_st[m] == 1)                         m_st[m] = 2;
            else if (m_st[m] == 2)                    m_st[m] = 0;
            else if (m == 1 && b)                     m_st[m] = 1;
        end
    endtask

    task automatic one_cycle();
        for (int m = 0; m < 2; m++) check_regs(m);
        drive(next_rand());
        #1;
        for (int m = 0; m < 2; m++) step(m);
    endtask

    task automatic reset_phase();
        rst_n = 1'b0;
        #1;
        repeat (3) @(negedge clk);
        model_reset();
        // R1: values held during reset
        for (int m = 0; m < 2; m++) check_regs(m);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int m = 0; m < 2; m++) begin
            if_br[m] = 0; if_off[m] = '0; ex_tk[m] = 0; ex_tg[m] = '0;
        end
        model_reset();
        reset_phase();
        repeat (2500) begin
            one_cycle();
            @(negedge clk);
        end
        reset_phase();
        repeat (2500) begin
            one_cycle();
            @(negedge clk);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule